// File: doc/BRIEF.md
# GHASH Karatsuba Field Multiplier

This block multiplies a 128-bit data word by a stored 128-bit hash key in GF(2^128), as needed once per block by the GHASH stage of an authenticated-encryption engine. The key is written once through a load strobe. At that point the block also precomputes and keeps the XOR of the key's two 64-bit halves. Every later multiplication is started with a single-cycle `start` pulse and finishes with a one-cycle `done` pulse that marks the registered result as valid.

Internally the 128x128 carry-less product is split one level, Karatsuba style, into three 64x64 carry-less products: low halves, high halves, and the XOR of the halves. These are computed one after another on a single shared digit-serial multiplier. The three partial products are recombined into a 256-bit value. That value is then reduced by two shift-and-XOR folds against the GCM polynomial. Operands and result follow GCM's reflected bit convention, and the mirroring is done in wiring at the block edge.

Top module: `ghash_kmul`

## Requirements
- R1: In the cycle after a synchronous reset, `busy` and `done` are 0 and `result` is all zeros.
- R2: `result` equals X·H in GF(2^128) modulo x^128 + x^7 + x^2 + x + 1. Bit 127 of every 128-bit port holds the coefficient of x^0 and bit 0 holds the coefficient of x^127.
- R3: A start is accepted on a clock edge where `start`=1, the block is idle, a key is present and `key_load`=0. With the default `DIGIT`=8, `done` is high for exactly one cycle, 29 cycles after that edge. In general the count is 3·(64/DIGIT+1)+2. `busy` is high from the cycle after acceptance until `done` rises.
- R4: A `start` while `busy` is ignored. The running operation keeps its operand and its completion time.
- R5: A `start` before any key has been loaded is ignored, and `busy` stays 0.
- R6: A `key_load` while idle replaces the key, and a `start` in the same cycle is ignored. A `key_load` while `busy` is ignored, so both the running operation and later ones use the previous key.
- R7: `result` changes only in a cycle where `done` is high, and otherwise holds its last value.
- R8: The latency does not depend on operand values. An all-zero X gives a zero result, and all-ones operands give the correct product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_load | input | 1 | Load `key_in` as the hash key (idle only) |
| key_in | input | 128 | Hash key H, reflected order |
| start | input | 1 | Begin a multiplication of `x_in` by H |
| x_in | input | 128 | Data operand X, reflected order |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, `result` valid |
| result | output | 128 | Reduced product X·H, reflected order |

## Verification
The assertions assume that `rst` is held for at least one edge before any stimulus. They also assume that `start` and `key_load` are sampled only at clock edges, so the acceptance condition they rebuild from the ports agrees with the block's own decision. The bench drives every input on the falling edge, holds `start` and `key_load` for exactly one cycle, and deliberately issues starts and key loads while `busy` is high, before any key exists, and together in the same cycle. These cases put the ignore rules under test without ever breaking the one-cycle framing that the latency and pulse properties depend on.

// File: rtl/ghm_pkg.sv
package ghm_pkg;
  localparam int unsigned BLK  = 128;
  localparam int unsigned HALF = BLK / 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LO,
    PH_HI,
    PH_MID,
    PH_COMB,
    PH_RED
  } phase_e;

  // Bit-order reversal between the reflected port convention and the
  // internal convention where index i is the coefficient of x^i.
  function automatic logic [BLK-1:0] mirror(input logic [BLK-1:0] v);
    logic [BLK-1:0] r;
    for (int i = 0; i < BLK; i++) r[i] = v[BLK-1-i];
    return r;
  endfunction
endpackage

// File: rtl/ghm_clmul_serial.sv
// Digit-serial carry-less multiplier: W x W -> 2W bits, D multiplier bits
// per cycle, MSB digit first. Fixed latency of W/D cycles after go.
module ghm_clmul_serial #(
  parameter int unsigned W = 64,
  parameter int unsigned D = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           fin,
  output logic [2*W-1:0] prod
);
  localparam int unsigned NDIG = W / D;
  localparam int unsigned CW   = $clog2(NDIG + 1);
  localparam int unsigned PW   = 2 * W;

  logic [W-1:0]   a_r, b_r;
  logic [PW-1:0]  acc;
  logic [CW-1:0]  cnt;
  logic           run, fin_r;
  logic [W+D-1:0] part;

  // Partial product of the multiplicand with the current top digit.
  always_comb begin
    part = '0;
    for (int i = 0; i < D; i++)
      if (b_r[W-D+i]) part = part ^ ((W+D)'(a_r) << i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_r   <= '0;
      b_r   <= '0;
      acc   <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      fin_r <= 1'b0;
    end else begin
      fin_r <= 1'b0;
      if (go) begin
        a_r <= a;
        b_r <= b;
        acc <= '0;
        cnt <= CW'(NDIG);
        run <= 1'b1;
      end else if (run) begin
        acc <= (acc << D) ^ PW'(part);
        b_r <= b_r << D;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run   <= 1'b0;
          fin_r <= 1'b1;
        end
      end
    end
  end

  assign fin  = fin_r;
  assign prod = acc;
endmodule

// File: rtl/ghm_key_store.sv
// Holds the (internally ordered) hash key halves and their XOR.
module ghm_key_store #(
  parameter int unsigned W = 128
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [W-1:0]   key_m,
  output logic [W/2-1:0] h_lo,
  output logic [W/2-1:0] h_hi,
  output logic [W/2-1:0] h_x,
  output logic           key_ok
);
  localparam int unsigned HW = W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_lo   <= '0;
      h_hi   <= '0;
      h_x    <= '0;
      key_ok <= 1'b0;
    end else if (load) begin
      h_lo   <= key_m[HW-1:0];
      h_hi   <= key_m[W-1:HW];
      h_x    <= key_m[HW-1:0] ^ key_m[W-1:HW];
      key_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/ghm_fold.sv
// Reduces a 2W-bit product modulo x^W + x^T + x^2 + x + 1 with two folds.
module ghm_fold #(
  parameter int unsigned W = 128,
  parameter int unsigned T = 7
) (
  input  logic [2*W-1:0] prod,
  output logic [W-1:0]   res
);
  localparam int unsigned EW = W + T;

  logic [W-1:0]  hi, lo, g;
  logic [EW-1:0] t, hx;
  logic [T-1:0]  ovf;

  always_comb begin
    hi  = prod[2*W-1:W];
    lo  = prod[W-1:0];
    hx  = EW'(hi);
    t   = hx ^ (hx << 1) ^ (hx << 2) ^ (hx << T);
    ovf = t[EW-1:W];
    g   = W'(ovf) ^ (W'(ovf) << 1) ^ (W'(ovf) << 2) ^ (W'(ovf) << T);
    res = lo ^ t[W-1:0] ^ g;
  end
endmodule

// File: rtl/ghash_kmul.sv
module ghash_kmul #(
  parameter int unsigned DIGIT = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         key_load,
  input  logic [127:0] key_in,
  input  logic         start,
  input  logic [127:0] x_in,
  output logic         busy,
  output logic         done,
  output logic [127:0] result
);
  import ghm_pkg::*;

  localparam int unsigned W       = BLK;
  localparam int unsigned HW      = HALF;
  localparam int unsigned LATENCY = 3 * (HW / DIGIT + 1) + 2;

  phase_e        ph;
  logic [HW-1:0] x_lo, x_hi;
  logic [W-1:0]  xm, folded;
  logic [W-1:0]  lo_p, hi_p, mid_p;
  logic [2*W-1:0] full;
  logic [W-1:0]  result_r;
  logic          done_r, busy_r;

  logic          key_ok, key_wr, accept;
  logic [HW-1:0] h_lo, h_hi, h_x;

  logic          m_go, m_fin;
  logic [HW-1:0] m_a, m_b;
  logic [W-1:0]  m_prod;

  assign xm     = mirror(x_in);
  assign key_wr = key_load && (ph == PH_IDLE);
  assign accept = start && (ph == PH_IDLE) && key_ok && !key_load;

  ghm_key_store #(.W(W)) u_key (
    .clk(clk), .rst(rst), .load(key_wr), .key_m(mirror(key_in)),
    .h_lo(h_lo), .h_hi(h_hi), .h_x(h_x), .key_ok(key_ok)
  );

  // Operand steering for the single shared 64x64 multiplier.
  always_comb begin
    m_go = 1'b0;
    m_a  = xm[HW-1:0];
    m_b  = h_lo;
    case (ph)
      PH_IDLE: m_go = accept;
      PH_LO: begin
        m_go = m_fin;
        m_a  = x_hi;
        m_b  = h_hi;
      end
      PH_HI: begin
        m_go = m_fin;
        m_a  = x_hi ^ x_lo;
        m_b  = h_x;
      end
      default: ;
    endcase
  end

  ghm_clmul_serial #(.W(HW), .D(DIGIT)) u_mul (
    .clk(clk), .rst(rst), .go(m_go), .a(m_a), .b(m_b),
    .fin(m_fin), .prod(m_prod)
  );

  ghm_fold #(.W(W), .T(7)) u_fold (
    .prod(full), .res(folded)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      x_lo     <= '0;
      x_hi     <= '0;
      lo_p     <= '0;
      hi_p     <= '0;
      mid_p    <= '0;
      full     <= '0;
      result_r <= '0;
      done_r   <= 1'b0;
      busy_r   <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (ph)
        PH_IDLE: if (accept) begin
          x_lo   <= xm[HW-1:0];
          x_hi   <= xm[W-1:HW];
          busy_r <= 1'b1;
          ph     <= PH_LO;
        end
        PH_LO: if (m_fin) begin
          lo_p <= m_prod;
          ph   <= PH_HI;
        end
        PH_HI: if (m_fin) begin
          hi_p <= m_prod;
          ph   <= PH_MID;
        end
        PH_MID: if (m_fin) begin
          mid_p <= m_prod;
          ph    <= PH_COMB;
        end
        PH_COMB: begin
          full <= {hi_p, lo_p} ^ ((2*W)'(mid_p ^ hi_p ^ lo_p) << HW);
          ph   <= PH_RED;
        end
        PH_RED: begin
          result_r <= mirror(folded);
          done_r   <= 1'b1;
          busy_r   <= 1'b0;
          ph       <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign busy   = busy_r;
  assign done   = done_r;
  assign result = result_r;
endmodule

// File: rtl/ghash_kmul_chk.sv
module ghash_kmul_chk #(
  parameter int unsigned LAT = 29
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         key_load,
  input logic         key_ok,
  input logic         busy,
  input logic         done,
  input logic [127:0] result
);
  logic [15:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (rst) lat_cnt <= '0;
    else if (start && !busy && key_ok && !key_load) lat_cnt <= '0;
    else if (busy) lat_cnt <= lat_cnt + 16'd1;
  end

  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r3_done_at_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_cnt == 16'(LAT)));
  a_r3_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  a_r4_busy_start_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
  a_r5_no_key_no_run: assert property (@(posedge clk) disable iff (rst)
    (!busy && !key_ok) |=> !busy);
  a_r7_result_holds: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);
endmodule

bind ghash_kmul ghash_kmul_chk #(.LAT(LATENCY)) u_chk (
  .clk(clk), .rst(rst), .start(start), .key_load(key_load),
  .key_ok(key_ok), .busy(busy), .done(done), .result(result)
);

// File: tb/ghash_kmul_tb.sv
module ghash_kmul_tb;
  localparam int DIGIT = 8;
  localparam int LAT   = 3 * (64 / DIGIT + 1) + 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         key_load = 1'b0;
  logic [127:0] key_in = '0;
  logic         start = 1'b0;
  logic [127:0] x_in = '0;
  logic         busy, done;
  logic [127:0] result;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [127:0] cur_key = '0;
  string scen = "R1";

  always #10 clk = ~clk;

  ghash_kmul #(.DIGIT(DIGIT)) u_dut (
    .clk(clk), .rst(rst), .key_load(key_load), .key_in(key_in),
    .start(start), .x_in(x_in), .busy(busy), .done(done), .result(result)
  );

  // Bit-serial GF(2^128) reference, reflected ordering.
  function automatic logic [127:0] gf_ref(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] z = '0;
    logic [127:0] v = b;
    for (int i = 0; i < 128; i++) begin
      if (a[127-i]) z = z ^ v;
      if (v[0]) v = (v >> 1) ^ {8'hE1, 120'h0};
      else      v = v >> 1;
    end
    return z;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Cycle-level behavioural model.
  logic         m_busy = 1'b0, m_done = 1'b0, m_keyok = 1'b0;
  logic [127:0] m_key = '0, m_x = '0, m_res = '0;
  int           m_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_keyok <= 1'b0;
      m_key <= '0; m_x <= '0; m_res <= '0; m_cnt <= 0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy) begin
        if (key_load) begin
          m_key <= key_in; m_keyok <= 1'b1;
        end else if (start && m_keyok) begin
          m_busy <= 1'b1; m_cnt <= LAT; m_x <= x_in;
        end
      end else begin
        if (m_cnt == 1) begin
          m_busy <= 1'b0; m_done <= 1'b1; m_res <= gf_ref(m_x, m_key);
        end
        m_cnt <= m_cnt - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(busy == m_busy, {scen, " R3 busy"}, 128'(busy), 128'(m_busy));
      chk(done == m_done, {scen, " R3 done"}, 128'(done), 128'(m_done));
      chk(result == m_res, m_done ? {scen, " R2 result"} : {scen, " R7 hold"}, result, m_res);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic load_key(input logic [127:0] k);
    @(negedge clk); key_load = 1'b1; key_in = k;
    @(negedge clk); key_load = 1'b0;
    cur_key = k;
  endtask

  // mode 0: plain, 1: extra start mid-run, 2: key load mid-run
  task automatic run_op(input logic [127:0] x, input int mode, input string tag);
    int n = 0;
    @(negedge clk); start = 1'b1; x_in = x;
    @(negedge clk); start = 1'b0;
    while (!done && n < 200) begin
      if (n == 5 && mode == 1) begin start = 1'b1; x_in = ~x; end
      else if (n == 5 && mode == 2) begin key_load = 1'b1; key_in = ~cur_key; end
      else begin start = 1'b0; key_load = 1'b0; end
      @(negedge clk); n++;
    end
    start = 1'b0; key_load = 1'b0;
    chk(n == LAT, {tag, " latency"}, 128'(n), 128'(LAT));
    chk(result == gf_ref(x, cur_key), {tag, " product"}, result, gf_ref(x, cur_key));
    @(negedge clk);
    chk(done == 1'b0, {tag, " R3 pulse width"}, 128'(done), 128'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(busy == 1'b0, "R1 busy", 128'(busy), 128'(0));
    chk(done == 1'b0, "R1 done", 128'(done), 128'(0));
    chk(result == '0, "R1 result", result, '0);

    scen = "R5";
    start = 1'b1; x_in = rnd128();
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R5 start without key", 128'(busy), 128'(0));

    scen = "R2";
    load_key(rnd128());
    run_op(128'h0, 0, "R8 zero operand");
    for (int i = 0; i < 6; i++) run_op(rnd128(), 0, "R2 random");
    run_op({1'b1, 127'h0}, 0, "R2 unit operand");

    scen = "R4";
    run_op(rnd128(), 1, "R4 start while busy");

    scen = "R6";
    run_op(rnd128(), 2, "R6 key load while busy");
    run_op(rnd128(), 0, "R6 old key kept");
    begin
      logic [127:0] k2 = rnd128();
      @(negedge clk); key_load = 1'b1; key_in = k2; start = 1'b1; x_in = rnd128();
      @(negedge clk); key_load = 1'b0; start = 1'b0;
      cur_key = k2;
      @(negedge clk);
      chk(busy == 1'b0, "R6 coincident start ignored", 128'(busy), 128'(0));
    end
    run_op(rnd128(), 0, "R6 new key used");

    scen = "R8";
    load_key({128{1'b1}});
    run_op({128{1'b1}}, 0, "R8 all ones");
    run_op(128'h0, 0, "R8 zero with ones key");

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule